// File: doc/BRIEF.md
# Programmable-Length Byte Delay Line

This block delays a byte stream by a number of clock stages set by a small length code. A byte enters on every rising clock edge and leaves, unaltered, a fixed number of edges later. The data never stalls, so the block has no valid/ready handshake and applies no back-pressure. The length code and the mode bit are plain control pins. Both are captured on every edge, like the data.

The byte travels as two independent nibble lanes. In uniform mode both lanes take the delay selected by the code. In split mode the lower nibble is held at the longest delay the block offers, while the upper nibble still follows the code.

A length change does not flush the pipeline. The output tap moves to its new position, so a longer setting repeats a sample and a shorter one drops samples. The parameter `MIN_LEN` sets the delay produced by code 0. The default of 3 gives delays of 3 to 18, and a setting of 1 gives delays of 1 to 16.

Top module: `prog_delay_line`

## Requirements
- R1: A synchronous active-high `rst` clears every pipeline stage, the captured code and the captured mode. While `rst` is held, and for the full delay after release with zero input, `dout` reads 0 even if `din` was non-zero during reset.
- R2: With the captured `split_mode` at 0, every bit of `din` sampled at edge t appears on `dout` right after edge t+D-1, where D = `len_code`+`MIN_LEN` and `len_code` is unsigned.
- R3: Code 0 gives the minimum delay `MIN_LEN` (3 by default) and code 15 gives the maximum `MIN_LEN`+15 (18 by default).
- R4: With the captured `split_mode` at 1, `dout[3:0]` has the maximum delay `MIN_LEN`+15 for every code, while `dout[7:4]` keeps the delay set by `len_code`.
- R5: `len_code` and `split_mode` are captured on an edge and first steer the output on the following edge.
- R6: When the length grows by one stage in mid-stream, the output repeats its previous value once. Nothing is flushed and no zero bubble is inserted.
- R7: When the length shrinks by k stages in mid-stream, k input samples never appear on the output.
- R8: Data values pass through bit for bit, including all-zeros, all-ones and single-bit patterns.
- R9: With `MIN_LEN` = 1, code n gives a delay of n+1 stages, so code 0 is a single register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | DW (8) | Input byte, sampled on every edge |
| len_code | input | LW (4) | Delay select; delay = code + MIN_LEN |
| split_mode | input | 1 | 0: both nibbles follow the code; 1: lower nibble fixed at maximum delay |
| dout | output | DW (8) | Delayed byte, driven from a register |

## Verification
The value on `dout` after edge t is due from `din` sampled at edge t−(MIN_LEN−1+c), where c and the mode are the values captured at edge t−1. The lower nibble in split mode instead uses the fixed offset MIN_LEN+14. The bench records the inputs of every edge in a history ring and samples `dout` on the falling edge, half a cycle after the edge that updated it. It recomputes this relation for a default instance and a `MIN_LEN` = 1 instance on every cycle. Because of this cycle-exact lookup, the one-edge lag of the code (R5) and the repeats and skips around a length change (R6, R7) are checked on the cycle where they occur.

// File: rtl/dly_pkg.sv
package dly_pkg;
  typedef enum logic {
    MODE_UNIFORM = 1'b0,
    MODE_SPLIT   = 1'b1
  } dly_mode_e;
endpackage

// File: rtl/dly_tap_chain.sv
// Shift chain for one lane: tap t carries the lane input delayed by MIN_LEN-1+t edges.
module dly_tap_chain #(
  parameter int W       = 4,
  parameter int TAPS    = 16,
  parameter int MIN_LEN = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] tap [TAPS]
);
  localparam int REGS = MIN_LEN + TAPS - 2;

  logic [W-1:0] st_q [1:REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i <= REGS; i++) st_q[i] <= '0;
    end else begin
      st_q[1] <= d_in;
      for (int i = 2; i <= REGS; i++) st_q[i] <= st_q[i-1];
    end
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    if (MIN_LEN - 1 + t == 0) begin : g_direct
      assign tap[t] = d_in;
    end else begin : g_reg
      assign tap[t] = st_q[MIN_LEN - 1 + t];
    end
  end
endmodule

// File: rtl/dly_tap_sel.sv
// 1-of-2**LW tap selector.
module dly_tap_sel #(
  parameter int W  = 4,
  parameter int LW = 4
) (
  input  logic [W-1:0]  tap [1 << LW],
  input  logic [LW-1:0] sel,
  output logic [W-1:0]  y
);
  always_comb y = tap[sel];
endmodule

// File: rtl/dly_lane.sv
// One nibble lane: chain, selector, output register.
module dly_lane #(
  parameter int W       = 4,
  parameter int LW      = 4,
  parameter int MIN_LEN = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  d_in,
  input  logic [LW-1:0] code,
  input  logic          fixed_max,
  output logic [W-1:0]  q
);
  localparam int TAPS = 1 << LW;

  logic [W-1:0]  tap [TAPS];
  logic [LW-1:0] sel_eff;
  logic [W-1:0]  picked;

  dly_tap_chain #(.W(W), .TAPS(TAPS), .MIN_LEN(MIN_LEN)) u_chain (
    .clk (clk),
    .rst (rst),
    .d_in(d_in),
    .tap (tap)
  );

  assign sel_eff = fixed_max ? LW'(TAPS - 1) : code;

  dly_tap_sel #(.W(W), .LW(LW)) u_sel (
    .tap(tap),
    .sel(sel_eff),
    .y  (picked)
  );

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= picked;
  end

  // R1: the last chain stage is empty right after a reset edge
  p_taps_clear_r1: assert property (@(posedge clk) rst |=> tap[TAPS-1] == '0)
    else $error("p_taps_clear_r1");

  // R4: the fixed lane emits what sat one stage short of the end two edges before
  p_fixed_tap_r4: assert property (@(posedge clk) disable iff (rst)
      (fixed_max && !$past(rst)) |=> q == $past(tap[TAPS-2], 2))
    else $error("p_fixed_tap_r4");
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line
  import dly_pkg::*;
#(
  parameter int DW      = 8,
  parameter int LW      = 4,
  parameter int MIN_LEN = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  logic [LW-1:0] len_code,
  input  logic          split_mode,
  output logic [DW-1:0] dout
);
  localparam int HW = DW / 2;

  logic [LW-1:0] code_q;
  dly_mode_e     mode_q;
  logic [1:0]    live_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      mode_q <= MODE_UNIFORM;
      live_q <= '0;
    end else begin
      code_q <= len_code;
      mode_q <= dly_mode_e'(split_mode);
      if (live_q != 2'd3) live_q <= live_q + 2'd1;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic fix;
    assign fix = (g == 0) && (mode_q == MODE_SPLIT);
    dly_lane #(.W(HW), .LW(LW), .MIN_LEN(MIN_LEN)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .d_in     (din[g*HW +: HW]),
      .code     (code_q),
      .fixed_max(fix),
      .q        (dout[g*HW +: HW])
    );
  end

  // R1: output reads zero after any reset edge
  p_reset_clears_r1: assert property (@(posedge clk) rst |=> dout == '0)
    else $error("p_reset_clears_r1");

  // R6: a one-stage length increase in uniform mode repeats the last output
  p_repeat_on_grow_r6: assert property (@(posedge clk) disable iff (rst)
      (live_q == 2'd3 && mode_q == MODE_UNIFORM && $past(mode_q) == MODE_UNIFORM &&
       {1'b0, code_q} == {1'b0, $past(code_q)} + 1'b1)
      |=> dout == $past(dout))
    else $error("p_repeat_on_grow_r6");
endmodule

// File: tb/prog_delay_line_bench.sv
module prog_delay_line_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] din;
  logic [3:0] code;
  logic       mode;
  logic [7:0] dout_a, dout_b;

  always #10 clk = ~clk;

  prog_delay_line #(.DW(8), .LW(4), .MIN_LEN(3)) u_prog_delay_line (
    .clk(clk), .rst(rst), .din(din), .len_code(code), .split_mode(mode), .dout(dout_a));

  prog_delay_line #(.DW(8), .LW(4), .MIN_LEN(1)) u_prog_delay_line_min1 (
    .clk(clk), .rst(rst), .din(din), .len_code(code), .split_mode(mode), .dout(dout_b));

  int n_chk = 0, n_bad = 0, ecnt = 0;
  bit chk_on = 0, done = 0;
  logic [7:0] hd [64];
  logic [3:0] hc [64];
  logic       hm [64];

  // history of what each edge captured (reset edges behave as zeros)
  always @(posedge clk) begin
    hd[ecnt % 64] <= rst ? 8'h00 : din;
    hc[ecnt % 64] <= rst ? 4'h0  : code;
    hm[ecnt % 64] <= rst ? 1'b0  : mode;
    ecnt <= ecnt + 1;
  end

  function automatic logic [7:0] model(int m, int t);
    int c, sh, sl;
    c  = hc[(t - 1) % 64];
    sh = t - (m - 1 + c);
    sl = hm[(t - 1) % 64] ? t - (m + 14) : sh;
    return {hd[sh % 64][7:4], hd[sl % 64][3:0]};
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h at edge %0d", tag, got, exp, ecnt);
    end
  endtask

  task automatic step(logic [7:0] d, logic [3:0] c, logic md, string tag);
    @(negedge clk);
    if (chk_on) begin
      check(tag, dout_a, model(3, ecnt - 1));
      check({tag, "/R9"}, dout_b, model(1, ecnt - 1));
    end
    din = d; code = c; mode = md;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog R1 got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; din = 8'hA5; code = 4'd5; mode = 1'b1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      din = 8'($urandom);
      if (i > 0) begin
        check("R1 reset", dout_a, 8'h00);
        check("R1 reset/R9", dout_b, 8'h00);
      end
    end
    rst = 1'b0; din = 8'h00; code = 4'd0; mode = 1'b0;
    chk_on = 1;
    // R1: zero input after release must give zero output, no stale reset-time data
    for (int i = 0; i < 24; i++) step(8'h00, 4'd0, 1'b0, "R1");
    // R2, R3: uniform mode, every code
    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 24; i++)
        step(8'($urandom), 4'(c), 1'b0, (c == 0 || c == 15) ? "R3" : "R2");
    // R4: split mode, every code
    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 24; i++) step(8'($urandom), 4'(c), 1'b1, "R4");
    // R8: pattern fidelity
    for (int i = 0; i < 40; i++) begin
      logic [7:0] p;
      p = (i % 4 == 0) ? 8'hFF : (i % 4 == 1) ? 8'h00 : 8'(1 << (i % 8));
      step(p, 4'd7, 1'b0, "R8");
    end
    // R6: grow one stage at a time, mid-stream, both modes
    for (int md = 0; md < 2; md++)
      for (int c = 0; c < 16; c++)
        for (int i = 0; i < 3; i++) step(8'(ecnt), 4'(c), md[0], "R6");
    // R7: shrink one stage and by larger jumps
    for (int c = 15; c >= 0; c--)
      for (int i = 0; i < 3; i++) step(8'(ecnt), 4'(c), 1'b0, "R7");
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 20; i++) step(8'(ecnt), 4'd15, 1'b0, "R7");
      for (int i = 0; i < 20; i++) step(8'(ecnt), 4'(15 - 2 * k - 1), 1'b0, "R7");
    end
    // R5: code and mode changing every cycle
    for (int i = 0; i < 300; i++) step(8'($urandom), 4'($urandom), 1'($urandom), "R5");
    for (int i = 0; i < 20; i++) step(8'h00, 4'd0, 1'b0, "R5");
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule